// File: doc/BRIEF.md
# Oversampled Serial Receiver with Multidrop Address Filter

This block receives asynchronous serial frames on a single RX line. It works from a clock enable that pulses sixteen times per bit. Each frame has one start bit, eight or nine data bits sent least significant bit first, and one stop bit. A complete frame is placed in a one-entry holding buffer, which raises a ready flag until the consumer pulses a read strobe. The stop bit of the buffered byte is reported as a framing-error flag.

In nine-bit mode the receiver can act as a node on a multidrop bus. With the address filter switched on, only frames whose ninth bit is 1 (address frames) reach the buffer, and all others are silently discarded. With the filter off, the ninth bit of every frame is handed out unchanged, so software can use it as a parity bit.

If a frame completes while the buffer is still unread, the receiver latches an overrun condition. It then stops accepting frames until the continuous-receive enable is dropped.

Top module: `async_addr_rx`

## Requirements
- R1: After reset, rx_ready, frame_err and overrun are 0. rx_data and rx_bit9 have no defined value until the first frame is loaded.
- R2: With nine_bit = 0, a frame with a low start bit, eight data bits (LSB first) and a stop bit loads its byte into rx_data, sets rx_bit9 to 0 and raises rx_ready.
- R3: With nine_bit = 1, the bit that follows the eight data bits is presented on rx_bit9 together with the byte.
- R4: While port_en is 0, RX activity assembles no frame, and the buffer and flags stay unchanged.
- R5: While cont_en is 0, no frame is received.
- R6: With nine_bit = 1 and addr_filt = 1, a frame whose ninth bit is 0 is discarded: rx_ready does not rise and the overrun flag is unaffected. A frame whose ninth bit is 1 is loaded.
- R7: With nine_bit = 1 and addr_filt = 0, every frame is loaded, whatever its ninth bit.
- R8: With nine_bit = 0, addr_filt has no effect and every frame is loaded.
- R9: When an accepted frame completes while rx_ready is 1, overrun is set and the frame is dropped. While overrun is 1, every later frame is dropped and rx_data does not change, even after a read.
- R10: overrun is cleared only by driving cont_en to 0. A read strobe does not clear it.
- R11: frame_err is loaded with 1 when the stop-bit sample of the loaded frame is 0, and with 0 otherwise. It keeps that value until the next frame is loaded.
- R12: A low pulse on RX that is high again at the middle of the start bit (sample 8 of 16) is taken as a false start. The receiver returns to idle and loads nothing.
- R13: A one-cycle pulse on rd_strobe clears rx_ready and leaves rx_data, rx_bit9 and frame_err unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Clock enable at 16 pulses per bit |
| rx_in | input | 1 | Serial input line, idle high |
| port_en | input | 1 | Enables the receiver as a whole |
| nine_bit | input | 1 | 1 selects nine data bits, 0 selects eight |
| cont_en | input | 1 | Enables continuous reception; driving it low clears overrun |
| addr_filt | input | 1 | Address filter enable, used only in nine-bit mode |
| rd_strobe | input | 1 | One-cycle pulse that consumes the buffered byte |
| rx_data | output | 8 | Buffered data byte |
| rx_bit9 | output | 1 | Ninth bit of the buffered frame |
| rx_ready | output | 1 | Buffer holds an unread frame |
| frame_err | output | 1 | Stop bit of the buffered frame was sampled low |
| overrun | output | 1 | A frame arrived while the buffer was full |

## Verification
The receiver is fed a random mix of byte values, ninth-bit values and good or broken stop bits. This runs under all four combinations of data width and address filter, so a wrong shift order or a lost ninth bit shows up as a data mismatch, and a filter applied in the wrong mode shows up as a missing or extra ready flag. The bench decides at random whether to read the buffer before the next frame, so the ready, overrun and drop paths are all taken, including frames that arrive after an overrun. Directed sequences cover a short false start, frames sent with the port enable or the continuous-receive enable low, and clearing overrun through the continuous-receive enable. Each of these can only be told apart from normal reception by watching whether rx_data and the flags change.

// File: rtl/async_addr_rx.sv
module async_addr_rx #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rx_in,
  input  logic       port_en,
  input  logic       nine_bit,
  input  logic       cont_en,
  input  logic       addr_filt,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_ready,
  output logic       frame_err,
  output logic       overrun
);
  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] MID  = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    idx;
  logic [8:0]    sh;
  logic          rx_m, rx_s;
  logic          done, stop_bit;

  wire       active   = port_en & cont_en;
  wire [3:0] last_idx = nine_bit ? 4'd8 : 4'd7;
  wire [7:0] f_data   = nine_bit ? sh[7:0] : sh[8:1];
  wire       f_b9     = nine_bit & sh[8];
  wire       keep     = !(nine_bit && addr_filt && !f_b9);
  wire       accept   = done && active && keep && !overrun;
  wire       load     = accept && !rx_ready;
  wire       ovr_set  = accept && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      done     <= 1'b0;
      stop_bit <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!active) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (baud_tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
          S_START: if (cnt == MID) begin
            cnt <= '0;
            idx <= '0;
            st  <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
          S_DATA: if (cnt == LAST) begin
            cnt <= '0;
            sh  <= {rx_s, sh[8:1]};
            idx <= idx + 1'b1;
            if (idx == last_idx) st <= S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
          S_STOP: if (cnt == LAST) begin
            cnt      <= '0;
            stop_bit <= rx_s;
            done     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready  <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (load) rx_ready <= 1'b1;
      else if (rd_strobe) rx_ready <= 1'b0;
      if (load) frame_err <= !stop_bit;
      if (!cont_en) overrun <= 1'b0;
      else if (ovr_set) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rx_data <= f_data;
      rx_bit9 <= f_b9;
    end
  end

  assert_ready_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(port_en && cont_en));
  assert_filter_passes_address_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) && $past(nine_bit && addr_filt) |-> rx_bit9);
  assert_eight_bit_no_ninth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) && !$past(nine_bit) |-> !rx_bit9);
  assert_overrun_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_ready));
  assert_overrun_freezes_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overrun) |-> $stable(rx_data) && !$rose(rx_ready));
  assert_overrun_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun) |-> !$past(cont_en));
endmodule

// File: tb/async_addr_rx_tb.sv
module async_addr_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic clk = 0, rst_n = 0, baud_tick = 0, rx_in = 1;
  logic port_en = 0, nine_bit = 0, cont_en = 0, addr_filt = 0, rd_strobe = 0;
  logic [7:0] rx_data;
  logic rx_bit9, rx_ready, frame_err, overrun;

  int checks = 0, errors = 0, cyc = 0, tdiv = 0;
  logic m_rdy = 0, m_ovr = 0, m_ferr = 0, m_b9 = 0, m_valid = 0;
  logic [7:0] m_data = 0;

  async_addr_rx dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV - 1);
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 190000", cyc);
      summary();
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(logic v, int n);
    rx_in = v;
    wait_clks(n);
  endtask

  function automatic void model_frame(logic [7:0] d, logic b9, logic sok);
    if (!(port_en && cont_en)) return;
    if (nine_bit && addr_filt && !b9) return;
    if (m_ovr) return;
    if (m_rdy) begin m_ovr = 1; return; end
    m_rdy = 1; m_data = d; m_b9 = nine_bit & b9; m_ferr = !sok; m_valid = 1;
  endfunction

  task automatic send(logic [7:0] d, logic b9, logic sok);
    drive_bit(0, BIT_CLKS);
    for (int i = 0; i < 8; i++) drive_bit(d[i], BIT_CLKS);
    if (nine_bit) drive_bit(b9, BIT_CLKS);
    if (sok) drive_bit(1, BIT_CLKS);
    else drive_bit(0, 3 * BIT_CLKS / 4);
    drive_bit(1, 3 * BIT_CLKS / 2);
    model_frame(d, b9, sok);
  endtask

  task automatic read_buf();
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    m_rdy = 0;
  endtask

  task automatic set_cont(logic v);
    cont_en = v;
    wait_clks(2);
    if (!v) m_ovr = 0;
  endtask

  task automatic check_all(string t_rdy, string t_ovr, string t_ferr, string t_data, string t_b9);
    check(t_rdy, rx_ready, m_rdy);
    check(t_ovr, overrun, m_ovr);
    check(t_ferr, frame_err, m_ferr);
    if (m_valid) begin
      check(t_data, rx_data, m_data);
      check(t_b9, rx_bit9, m_b9);
    end
  endtask

  initial begin
    wait_clks(3);
    check("R1 ready", rx_ready, 0);
    check("R1 ferr", frame_err, 0);
    check("R1 overrun", overrun, 0);
    rst_n = 1;
    wait_clks(3);
    check("R1 ready after release", rx_ready, 0);

    port_en = 1; cont_en = 1; wait_clks(4);
    send(8'hA5, 0, 1);
    check_all("R2", "R2", "R2", "R2 data", "R2 bit9");
    read_buf(); wait_clks(1);
    check("R13 ready cleared", rx_ready, 0);
    check("R13 data held", rx_data, 8'hA5);

    send(8'h3C, 0, 0);
    check_all("R11", "R11", "R11 ferr set", "R11", "R11");
    read_buf(); wait_clks(1);
    check("R13 ferr held after read", frame_err, 1);
    send(8'h5A, 0, 1);
    check_all("R11", "R11", "R11 ferr cleared", "R11", "R11");
    read_buf();

    send(8'h11, 0, 1);
    send(8'h22, 0, 1);
    check_all("R9", "R9 overrun set", "R9", "R9 data kept", "R9");
    read_buf();
    send(8'h33, 0, 1);
    check_all("R9 drop after read", "R9", "R9", "R9 data frozen", "R9");
    check("R10 read keeps overrun", overrun, 1);
    set_cont(0);
    check("R10 overrun cleared", overrun, 0);
    set_cont(1);

    nine_bit = 1; addr_filt = 1;
    send(8'h44, 0, 1);
    check_all("R6 data frame dropped", "R6", "R6", "R6", "R6");
    send(8'h45, 1, 1);
    check_all("R6 address frame loaded", "R6", "R6", "R6 data", "R3 bit9");
    read_buf();
    addr_filt = 0;
    send(8'h46, 0, 1);
    check_all("R7 loaded", "R7", "R7", "R7 data", "R7 bit9");
    read_buf();
    nine_bit = 0; addr_filt = 1;
    send(8'h47, 0, 1);
    check_all("R8 loaded", "R8", "R8", "R8 data", "R8 bit9");
    read_buf();

    port_en = 0;
    send(8'h99, 1, 1);
    check_all("R4 no frame", "R4", "R4", "R4 data", "R4");
    port_en = 1; cont_en = 0;
    send(8'h98, 1, 1);
    check_all("R5 no frame", "R5", "R5", "R5 data", "R5");
    cont_en = 1; wait_clks(4);

    drive_bit(0, BIT_CLKS / 4);
    drive_bit(1, 2 * BIT_CLKS);
    check_all("R12 false start", "R12", "R12", "R12", "R12");
    send(8'hC3, 0, 1);
    check_all("R12 recovers", "R12", "R12", "R12 data", "R12");
    read_buf();

    void'($urandom(32'h1234_5678));
    for (int it = 0; it < 100; it++) begin
      logic [7:0] d;
      int r;
      d = 8'($urandom);
      r = int'($urandom % 100);
      if (r < 10) begin
        nine_bit = 1'($urandom);
        addr_filt = 1'($urandom);
      end
      send(d, 1'($urandom), ($urandom % 100) >= 15);
      check_all("R6 rand ready", "R9 rand overrun", "R11 rand ferr", "R2 rand data", "R3 rand bit9");
      if (($urandom % 100) < 60) read_buf();
      if (($urandom % 100) < 12) begin
        set_cont(0);
        check("R10 rand clear", overrun, 0);
        set_cont(1);
      end
    end
    summary();
  end
endmodule